// File: doc/BRIEF.md
# VLIW Bundle Issue Controller

This block takes very long instruction words from a fetch window of two words and hands them to a set of execution units. Each word has one fixed-width operation field per unit. Every field of an issued word reaches its own unit in the same cycle. The hardware does no dependency analysis. The only thing that decides the issue width is a flag that the compiler places in each word.

With two issue lanes, the second word of a fetch pair goes out together with the first when its flag says it is independent. If the flag marks it dependent, it is parked and issued alone in the following cycle, and the input is stalled during that cycle. A one-lane build takes the same instruction stream one word per cycle and ends with the same unit results.

A pair mode always takes both words of a fetch together and ignores the flag. In this mode the first word is tagged integer class and the second is tagged floating-point class. Each execution unit is modelled as a result register. The register latches the last non-zero operation field sent to it.

Top module: `bundle_issue_ctrl`

## Requirements
- R1: A word is 65 bits wide. Slot s occupies bits [16s+15:16s], with s=0 for the first ALU, 1 for the second ALU, 2 for the multiplier and 3 for the load/store unit. Bit 64 is the dependency flag. Slot s updates only result field s, which is `unit_res[16s+15:16s]`.
- R2: A word accepted at a clock edge (in_vld and in_rdy high) appears complete on its lane of `iss_ops` after that edge, with `iss_vld` set. The unit results change one edge later.
- R3: An all-zero slot is a no-op and leaves its result field unchanged. With nothing issued, no result changes.
- R4: With in_two=1, pair_mode=0 and the second word's flag clear, both words issue in the same cycle: word 0 on lane 0 (`iss_ops[63:0]`) and word 1 on lane 1 (`iss_ops[127:64]`). Lane 1 is never active without lane 0.
- R5: With in_two=1, pair_mode=0 and the second word's flag set, word 0 issues alone on lane 0. Word 1 issues alone on lane 0 in the next cycle, and in_rdy is low for exactly that cycle.
- R6: When both lanes carry a non-zero field for the same unit in one cycle, the unit keeps lane 1's field (the later word).
- R7: With in_two=0 and pair_mode=0, only word 0 issues, on lane 0. Its own flag and the second word's contents have no effect.
- R8: With pair_mode=1, both words issue together whatever their flags are. `iss_fp` is 2'b10: lane 0 is integer class (0) and lane 1 is floating-point class (1).
- R9: After reset, in_rdy is 1, iss_vld is 0 and every result field is 0.
- R10: A build with LANES=1 that runs the same instruction stream ends with the same unit results as the two-lane build.
- R11: While in_vld is low and no word is parked, nothing issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Fetch window holds valid words |
| in_rdy | output | 1 | Controller accepts the fetch window this cycle |
| in_two | input | 1 | Second word of the window is present |
| pair_mode | input | 1 | Integer/floating-point pairing mode |
| in_words | input | 130 | Two 65-bit words, word 0 in the low half |
| iss_vld | output | LANES | Per-lane issue valid |
| iss_fp | output | LANES | Per-lane operation class, 1 = floating point |
| iss_ops | output | 64*LANES | Per-lane slot fields presented to the units |
| unit_res | output | 64 | Result registers of the four units |

## Verification
The issue path is driven with these patterns:
- a lone word whose own flag is set;
- a pair whose second word is independent;
- a pair whose second word is dependent;
- a pair with a dependent flag under pair mode;
- words with zeroed slots.

Comparing these cases separates gang issue from the split-and-stall path, and shows whether the flag is wrongly honoured or wrongly ignored. Fields for the same unit placed in both lanes expose a wrong lane priority. Zero slots and idle cycles show whether a no-op writes a result. A mixed stream, with dependent and independent pairs and a lone word, is run on both a one-lane and a two-lane build, and their final results are compared with each other and with a model.

// File: rtl/bic_pkg.sv
`timescale 1ns/1ps
package bic_pkg;
  typedef enum logic [1:0] {SL_ALU0 = 2'd0, SL_ALU1 = 2'd1, SL_MUL = 2'd2, SL_LDST = 2'd3} slot_e;
  typedef enum logic {CLS_INT = 1'b0, CLS_FP = 1'b1} op_class_e;
  localparam int unsigned FETCH_WORDS = 2;
endpackage

// File: rtl/bic_lane_pick.sv
`timescale 1ns/1ps
module bic_lane_pick
  import bic_pkg::*;
#(
  parameter int unsigned LANES  = 2,
  parameter int unsigned SLOTS  = 4,
  parameter int unsigned SLOT_W = 16,
  localparam int unsigned DATA_W = SLOTS * SLOT_W,
  localparam int unsigned WORD_W = DATA_W + 1
) (
  input  logic                             hold_vld,
  input  logic [DATA_W-1:0]                hold_ops,
  input  logic                             hold_cls,
  input  logic                             take,
  input  logic                             in_two,
  input  logic                             pair_mode,
  input  logic [FETCH_WORDS*WORD_W-1:0]    in_words,
  output logic [LANES-1:0]                 nxt_vld,
  output logic [LANES*DATA_W-1:0]          nxt_ops,
  output logic [LANES-1:0]                 nxt_fp,
  output logic                             park,
  output logic [DATA_W-1:0]                park_ops,
  output logic                             park_cls
);
  logic [DATA_W-1:0] w0_ops, w1_ops;
  logic              w1_dep, second, gang;
  logic              l0_vld, l0_fp;
  logic [DATA_W-1:0] l0_ops;

  assign w0_ops = in_words[DATA_W-1:0];
  assign w1_ops = in_words[WORD_W+DATA_W-1:WORD_W];
  assign w1_dep = in_words[2*WORD_W-1];
  assign second = in_two | pair_mode;

  always_comb begin
    l0_vld = 1'b0;
    l0_ops = '0;
    l0_fp  = CLS_INT;
    if (hold_vld) begin
      l0_vld = 1'b1;
      l0_ops = hold_ops;
      l0_fp  = hold_cls;
    end else if (take) begin
      l0_vld = 1'b1;
      l0_ops = w0_ops;
    end
  end

  assign park     = ~hold_vld & take & second & ~gang;
  assign park_ops = w1_ops;
  assign park_cls = pair_mode ? CLS_FP : CLS_INT;

  generate
    if (LANES > 1) begin : g_wide
      logic l1_vld;
      assign gang    = pair_mode | ~w1_dep;
      assign l1_vld  = ~hold_vld & take & second & gang;
      assign nxt_vld = {l1_vld, l0_vld};
      assign nxt_ops = {(l1_vld ? w1_ops : {DATA_W{1'b0}}), l0_ops};
      assign nxt_fp  = {(l1_vld & pair_mode), l0_fp};
    end else begin : g_narrow
      assign gang    = 1'b0;
      assign nxt_vld = l0_vld;
      assign nxt_ops = l0_ops;
      assign nxt_fp  = l0_fp;
    end
  endgenerate
endmodule

// File: rtl/bic_result_bank.sv
`timescale 1ns/1ps
module bic_result_bank #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned SLOTS  = 4,
  parameter int unsigned SLOT_W = 16,
  localparam int unsigned DATA_W = SLOTS * SLOT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        iss_vld,
  input  logic [LANES*DATA_W-1:0] iss_ops,
  output logic [DATA_W-1:0]       unit_res
);
  generate
    for (genvar s = 0; s < SLOTS; s++) begin : g_unit
      logic [SLOT_W-1:0] res_q, res_d;
      logic              wr_en;

      always_comb begin
        res_d = res_q;
        wr_en = 1'b0;
        for (int l = 0; l < LANES; l++) begin
          if (iss_vld[l] && (iss_ops[l*DATA_W + s*SLOT_W +: SLOT_W] != '0)) begin
            res_d = iss_ops[l*DATA_W + s*SLOT_W +: SLOT_W];
            wr_en = 1'b1;
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     res_q <= '0;
        else if (wr_en) res_q <= res_d;
      end

      assign unit_res[s*SLOT_W +: SLOT_W] = res_q;
    end
  endgenerate
endmodule

// File: rtl/bundle_issue_ctrl.sv
`timescale 1ns/1ps
module bundle_issue_ctrl
  import bic_pkg::*;
#(
  parameter int unsigned LANES  = 2,
  parameter int unsigned SLOTS  = 4,
  parameter int unsigned SLOT_W = 16,
  localparam int unsigned DATA_W = SLOTS * SLOT_W,
  localparam int unsigned WORD_W = DATA_W + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_vld,
  output logic                          in_rdy,
  input  logic                          in_two,
  input  logic                          pair_mode,
  input  logic [FETCH_WORDS*WORD_W-1:0] in_words,
  output logic [LANES-1:0]              iss_vld,
  output logic [LANES-1:0]              iss_fp,
  output logic [LANES*DATA_W-1:0]       iss_ops,
  output logic [DATA_W-1:0]             unit_res
);
  logic                    hold_vld_q, hold_cls_q;
  logic [DATA_W-1:0]       hold_ops_q;
  logic                    take, park, park_cls;
  logic [DATA_W-1:0]       park_ops;
  logic [LANES-1:0]        nxt_vld, nxt_fp;
  logic [LANES*DATA_W-1:0] nxt_ops;
  logic                    iss_en;

  assign in_rdy = ~hold_vld_q;
  assign take   = in_vld & in_rdy;
  assign iss_en = |nxt_vld;

  bic_lane_pick #(.LANES(LANES), .SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_pick (
    .hold_vld (hold_vld_q),
    .hold_ops (hold_ops_q),
    .hold_cls (hold_cls_q),
    .take     (take),
    .in_two   (in_two),
    .pair_mode(pair_mode),
    .in_words (in_words),
    .nxt_vld  (nxt_vld),
    .nxt_ops  (nxt_ops),
    .nxt_fp   (nxt_fp),
    .park     (park),
    .park_ops (park_ops),
    .park_cls (park_cls)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld_q <= 1'b0;
      iss_vld    <= '0;
      iss_fp     <= '0;
    end else begin
      hold_vld_q <= park;
      iss_vld    <= nxt_vld;
      iss_fp     <= nxt_fp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_ops_q <= '0;
      hold_cls_q <= CLS_INT;
    end else if (park) begin
      hold_ops_q <= park_ops;
      hold_cls_q <= park_cls;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      iss_ops <= '0;
    else if (iss_en) iss_ops <= nxt_ops;
  end

  bic_result_bank #(.LANES(LANES), .SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .iss_vld (iss_vld),
    .iss_ops (iss_ops),
    .unit_res(unit_res)
  );
endmodule

// File: rtl/bic_checker.sv
`timescale 1ns/1ps
module bic_checker #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned SLOTS  = 4,
  parameter int unsigned SLOT_W = 16,
  localparam int unsigned DATA_W = SLOTS * SLOT_W,
  localparam int unsigned WORD_W = DATA_W + 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_vld,
  input logic                    in_rdy,
  input logic                    in_two,
  input logic                    pair_mode,
  input logic [2*WORD_W-1:0]     in_words,
  input logic [LANES-1:0]        iss_vld,
  input logic [LANES-1:0]        iss_fp,
  input logic [LANES*DATA_W-1:0] iss_ops,
  input logic [DATA_W-1:0]       unit_res
);
  logic acc, w1_dep;
  assign acc    = in_vld & in_rdy;
  assign w1_dep = in_words[2*WORD_W-1];

  // R11
  idle_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rdy && !in_vld) |=> (iss_vld == '0));

  // R3
  idle_res_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld == '0) |=> $stable(unit_res));

  generate
    if (LANES == 2) begin : g_two
      // R5
      dep_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_two && !pair_mode && w1_dep) |=> (!in_rdy && iss_vld == 2'b01));

      // R5
      held_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_rdy |=> (in_rdy && iss_vld == 2'b01));

      // R4
      gang_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_two && !pair_mode && !w1_dep) |=>
          (iss_vld == 2'b11 && iss_ops[2*DATA_W-1:DATA_W] == $past(in_words[WORD_W+DATA_W-1:WORD_W])));

      // R4
      lane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld[1] |-> iss_vld[0]);

      // R8
      pair_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && pair_mode) |=> (iss_vld == 2'b11 && iss_fp == 2'b10));

      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        // R1
        route_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (iss_vld == 2'b01 && iss_ops[s*SLOT_W +: SLOT_W] != '0) |=>
            (unit_res[s*SLOT_W +: SLOT_W] == $past(iss_ops[s*SLOT_W +: SLOT_W])));

        // R6
        later_lane_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (iss_vld == 2'b11 && iss_ops[DATA_W + s*SLOT_W +: SLOT_W] != '0) |=>
            (unit_res[s*SLOT_W +: SLOT_W] == $past(iss_ops[DATA_W + s*SLOT_W +: SLOT_W])));

        // R3
        noop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (iss_vld == 2'b01 && iss_ops[s*SLOT_W +: SLOT_W] == '0) |=>
            $stable(unit_res[s*SLOT_W +: SLOT_W]));
      end
    end else begin : g_one
      // R5
      narrow_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (in_two || pair_mode)) |=> !in_rdy);
    end
  endgenerate
endmodule

bind bundle_issue_ctrl bic_checker #(.LANES(LANES), .SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_vld   (in_vld),
  .in_rdy   (in_rdy),
  .in_two   (in_two),
  .pair_mode(pair_mode),
  .in_words (in_words),
  .iss_vld  (iss_vld),
  .iss_fp   (iss_fp),
  .iss_ops  (iss_ops),
  .unit_res (unit_res)
);

// File: tb/sim_bundle_issue_ctrl.sv
`timescale 1ns/1ps
module sim_bundle_issue_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  // two-lane build
  logic         a_vld, a_two, a_pm, a_rdy;
  logic [129:0] a_words;
  logic [1:0]   a_iss_vld, a_iss_fp;
  logic [127:0] a_iss_ops;
  logic [63:0]  a_res;

  // one-lane build
  logic         b_vld, b_two, b_pm, b_rdy;
  logic [129:0] b_words;
  logic [0:0]   b_iss_vld, b_iss_fp;
  logic [63:0]  b_iss_ops;
  logic [63:0]  b_res;

  bundle_issue_ctrl #(.LANES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(a_vld), .in_rdy(a_rdy), .in_two(a_two),
    .pair_mode(a_pm), .in_words(a_words), .iss_vld(a_iss_vld), .iss_fp(a_iss_fp),
    .iss_ops(a_iss_ops), .unit_res(a_res));

  bundle_issue_ctrl #(.LANES(1)) u1 (
    .clk(clk), .rst_n(rst_n), .in_vld(b_vld), .in_rdy(b_rdy), .in_two(b_two),
    .pair_mode(b_pm), .in_words(b_words), .iss_vld(b_iss_vld), .iss_fp(b_iss_fp),
    .iss_ops(b_iss_ops), .unit_res(b_res));

  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;
  logic [63:0] exp_res;

  task automatic chk(input string req, input logic [131:0] got, input logic [131:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [64:0] mk(input logic dep, input logic [15:0] ldst,
                                     input logic [15:0] mul, input logic [15:0] alu1,
                                     input logic [15:0] alu0);
    return {dep, ldst, mul, alu1, alu0};
  endfunction

  function automatic logic [63:0] merge(input logic [63:0] cur, input logic [64:0] w);
    logic [63:0] r = cur;
    for (int s = 0; s < 4; s++)
      if (w[s*16 +: 16] != 16'h0) r[s*16 +: 16] = w[s*16 +: 16];
    return r;
  endfunction

  task automatic fire(input logic [64:0] w0, input logic [64:0] w1, input logic two, input logic pm);
    @(negedge clk);
    a_words = {w1, w0}; a_two = two; a_pm = pm; a_vld = 1'b1;
    while (!a_rdy) @(negedge clk);
    @(posedge clk); #1;
    a_vld = 1'b0; a_two = 1'b0; a_pm = 1'b0;
  endtask

  task automatic t_reset;
    chk("R9 in_rdy", a_rdy, 1'b1);
    chk("R9 iss_vld", a_iss_vld, 2'b00);
    chk("R9 unit_res", a_res, 64'h0);
    exp_res = 64'h0;
  endtask

  task automatic t_single;
    logic [64:0] w = mk(1'b1, 16'h4444, 16'h3333, 16'h2222, 16'h1111);
    fire(w, mk(1'b0, 16'h9999, 16'h9999, 16'h9999, 16'h9999), 1'b0, 1'b0);
    chk("R7 lone word lane0 only", a_iss_vld, 2'b01);
    chk("R2 slots presented together", a_iss_ops[63:0], w[63:0]);
    chk("R7 no stall", a_rdy, 1'b1);
    @(posedge clk); #1;
    exp_res = merge(exp_res, w);
    chk("R1 slot routing", a_res, exp_res);
    chk("R11 nothing issued when idle", a_iss_vld, 2'b00);
  endtask

  task automatic t_noop;
    logic [64:0] w = mk(1'b0, 16'h00D4, 16'h0000, 16'h00B2, 16'h00A1);
    fire(w, 65'h0, 1'b0, 1'b0);
    @(posedge clk); #1;
    exp_res = merge(exp_res, w);
    chk("R3 zero slot keeps result", a_res, exp_res);
    chk("R3 multiplier field unchanged", a_res[47:32], 16'h3333);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      chk("R11 idle no issue", a_iss_vld, 2'b00);
    end
    chk("R3 idle results stable", a_res, exp_res);
  endtask

  task automatic t_pair;
    logic [64:0] w0 = mk(1'b0, 16'h0000, 16'h0C0C, 16'h0B0B, 16'h0A0A);
    logic [64:0] w1 = mk(1'b0, 16'h1D1D, 16'h0000, 16'h0000, 16'h1A1A);
    fire(w0, w1, 1'b1, 1'b0);
    chk("R4 both lanes issue", a_iss_vld, 2'b11);
    chk("R4 lane order", a_iss_ops, {w1[63:0], w0[63:0]});
    chk("R4 integer class", a_iss_fp, 2'b00);
    @(posedge clk); #1;
    exp_res = merge(merge(exp_res, w0), w1);
    chk("R6 later word wins", a_res[15:0], 16'h1A1A);
    chk("R4 pair results", a_res, exp_res);
  endtask

  task automatic t_dep;
    logic [64:0] w0 = mk(1'b0, 16'h002D, 16'h002C, 16'h0000, 16'h0000);
    logic [64:0] w1 = mk(1'b1, 16'h0000, 16'h003C, 16'h003B, 16'h0000);
    fire(w0, w1, 1'b1, 1'b0);
    chk("R5 first word alone", a_iss_vld, 2'b01);
    chk("R5 first word ops", a_iss_ops[63:0], w0[63:0]);
    chk("R5 input stalled", a_rdy, 1'b0);
    @(posedge clk); #1;
    exp_res = merge(exp_res, w0);
    chk("R5 second word alone", a_iss_vld, 2'b01);
    chk("R5 second word ops", a_iss_ops[63:0], w1[63:0]);
    chk("R5 stall released", a_rdy, 1'b1);
    chk("R5 first results", a_res, exp_res);
    @(posedge clk); #1;
    exp_res = merge(exp_res, w1);
    chk("R5 second results", a_res, exp_res);
  endtask

  task automatic t_pairmode;
    logic [64:0] w0 = mk(1'b1, 16'h0000, 16'h0000, 16'h0000, 16'h0E01);
    logic [64:0] w1 = mk(1'b1, 16'h0000, 16'h0F02, 16'h0000, 16'h0000);
    fire(w0, w1, 1'b0, 1'b1);
    chk("R8 both issue despite flag", a_iss_vld, 2'b11);
    chk("R8 class tags", a_iss_fp, 2'b10);
    chk("R8 no stall", a_rdy, 1'b1);
    @(posedge clk); #1;
    exp_res = merge(merge(exp_res, w0), w1);
    chk("R8 results", a_res, exp_res);
  endtask

  function automatic logic [15:0] pv(input int i, input int lane, input int s);
    if (i == 0 && lane == 0) return 16'h5000 + 16'(s + 1);
    if (((i + s + lane) % 3) == 0) return 16'h0000;
    return {4'(6 + lane), 4'(s), 8'(i)};
  endfunction

  function automatic logic [64:0] pw(input int i, input int lane);
    logic dep = (lane == 1) ? 1'(i) : 1'b0;
    return mk(dep, pv(i, lane, 3), pv(i, lane, 2), pv(i, lane, 1), pv(i, lane, 0));
  endfunction

  task automatic t_narrow;
    logic [63:0] m = 64'h0;
    for (int i = 0; i < 6; i++) begin
      m = merge(m, pw(i, 0));
      if (i != 3) m = merge(m, pw(i, 1));
    end
    fork
      begin
        for (int i = 0; i < 6; i++) begin
          @(negedge clk);
          a_words = {pw(i, 1), pw(i, 0)}; a_two = (i != 3); a_pm = 1'b0; a_vld = 1'b1;
          while (!a_rdy) @(negedge clk);
          @(posedge clk); #1;
        end
        a_vld = 1'b0; a_two = 1'b0;
      end
      begin
        for (int i = 0; i < 6; i++) begin
          @(negedge clk);
          b_words = {pw(i, 1), pw(i, 0)}; b_two = (i != 3); b_pm = 1'b0; b_vld = 1'b1;
          while (!b_rdy) @(negedge clk);
          @(posedge clk); #1;
        end
        b_vld = 1'b0; b_two = 1'b0;
      end
    join
    repeat (4) @(posedge clk);
    #1;
    chk("R10 two-lane stream result", a_res, m);
    chk("R10 one-lane stream result", b_res, m);
    chk("R10 builds agree", b_res, a_res);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    a_vld = 1'b0; a_two = 1'b0; a_pm = 1'b0; a_words = '0;
    b_vld = 1'b0; b_two = 1'b0; b_pm = 1'b0; b_words = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset;
    t_single;
    t_noop;
    t_pair;
    t_dep;
    t_pairmode;
    t_narrow;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule